// File: doc/BRIEF.md
# One-Bit Boolean Stack Controller

This block is a small controller core for replacing relay ladder logic. It fetches one 8-bit instruction per clock from an external program ROM and evaluates boolean expressions on an eight-entry stack of single bits. It reads single-bit lines from a parallel input bus, holds intermediate results in a paged bit store, and drives a registered output bus. A program is a straight list of bytes that usually ends in a restart instruction, so the core scans the whole rung list again and again, the way a relay panel settles continuously.

Each byte uses one of two formats. In the addressed format the upper five bits name a line or cell from 0 to 29 and the lower three bits choose the operation. When the upper five bits are 30 or 31 the byte is a stand-alone stack operation. The ROM read port has a fixed latency of one cycle and no back-pressure. The core never stalls. The only cycle it does not execute is the one after a restart, when it discards the byte already fetched. The input bus is sampled directly in the cycle it is used.

Top module: `bsp_core`

## Requirements
- R1: A synchronous active-high reset clears `out_bus`, sets `rom_addr` to 0, clears every store cell, selects store page 0 and leaves a stack whose top is 1 and whose other entries are 0.
- R2: An addressed byte `{a[4:0],3'b000}` sets top to top AND `in_bus[a]`. `{a,3'b001}` sets top to top AND NOT `in_bus[a]`.
- R3: `{a,3'b010}` sets top to top AND cell a, and `{a,3'b011}` sets top to top AND NOT cell a. `{a,3'b110}` copies top into cell a and then sets top to 1.
- R4: `{a,3'b100}` and `{a,3'b101}` do the same as 010 and 011, and then push a 1, so the result sits one entry below the new top.
- R5: `{a,3'b111}` copies top into `out_bus[a]` and sets top to 1. `out_bus` changes only on this instruction.
- R6: 0xF1 inverts top. 0xF4 pushes 0, 0xF5 pushes 1, 0xF6 pushes a copy of top, and 0xF7 pops.
- R7: 0xF8, 0xF9 and 0xFA replace top with top AND, OR or XOR the entry below it. The entry below is kept.
- R8: 0xFC, 0xFD and 0xFE write top AND, OR or XOR the entry below it in place of top, then push a 1. The combined value ends up one entry below the new top.
- R9: 0xFB and 0xFF change no state except the program counter.
- R10: 0xF0 sends the program counter back to 0. The byte fetched after it is not executed.
- R11: 0xF2 steps a 2-bit page register that selects which group of 30 store cells the addressed store operations use, wrapping from page 3 to page 0. 0xF3 returns to page 0. The input and output lines are not paged.
- R12: The stack holds 8 bits. A push onto 8 entries discards the oldest one, and once more pops than entries have occurred, top reads 0.
- R13: The core executes one instruction per clock. The byte at address k takes effect at the (k+2)th rising edge after reset is released. `rom_addr` advances by one per clock and wraps from 1023 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rom_addr | output | 10 | Program ROM read address |
| rom_data | input | 8 | ROM byte for the address presented one cycle earlier |
| in_bus | input | 30 | Parallel single-bit input lines |
| out_bus | output | 30 | Registered single-bit output lines |

## Verification
The assertions assume that `rom_data` always holds the byte for the address presented on the previous edge, with no wait state, and that reset is synchronous and lasts at least one edge. The bench keeps within this. Its ROM model is a plain registered array indexed by `rom_addr`, and it changes `rst` and `in_bus` only on falling edges. Each program is short enough to finish well before the counter wraps, so no rung runs twice before it is checked. The exceptions are the restart and wrap scenarios, where repetition is the behaviour under test.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  localparam int unsigned INSN_W = 8;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [2:0] {
    TOP_KEEP,
    TOP_OPND,
    TOP_ONE,
    TOP_INV,
    TOP_AND_BL,
    TOP_OR_BL,
    TOP_XOR_BL
  } top_op_e;

  typedef enum logic [1:0] {
    PV_ZERO,
    PV_ONE,
    PV_TOP
  } push_val_e;

  // addressed-format operation field, insn[2:0]
  typedef enum logic [2:0] {
    AOP_AND_IN     = 3'd0,
    AOP_ANDN_IN    = 3'd1,
    AOP_AND_ST     = 3'd2,
    AOP_ANDN_ST    = 3'd3,
    AOP_AND_ST_P1  = 3'd4,
    AOP_ANDN_ST_P1 = 3'd5,
    AOP_STORE      = 3'd6,
    AOP_OUT        = 3'd7
  } aop_e;

  // stand-alone format, insn[3:0] of 0xF0..0xFF
  typedef enum logic [3:0] {
    XOP_RESTART = 4'h0,
    XOP_INVERT  = 4'h1,
    XOP_PAGE    = 4'h2,
    XOP_HOME    = 4'h3,
    XOP_PUSH0   = 4'h4,
    XOP_PUSH1   = 4'h5,
    XOP_PUSHC   = 4'h6,
    XOP_POP     = 4'h7,
    XOP_AND     = 4'h8,
    XOP_OR      = 4'h9,
    XOP_XOR     = 4'hA,
    XOP_CMP     = 4'hB,
    XOP_PAND    = 4'hC,
    XOP_POR     = 4'hD,
    XOP_PXOR    = 4'hE,
    XOP_PCMP    = 4'hF
  } xop_e;

  typedef struct packed {
    top_op_e             top_op;
    logic                opnd_store;
    logic                opnd_neg;
    logic                push;
    logic                pop;
    push_val_e           push_val;
    logic                store_wr;
    logic                out_wr;
    logic                restart;
    logic                page_inc;
    logic                page_home;
    logic [ADDR_W-1:0]   addr;
  } ctrl_t;

endpackage

// File: rtl/bsp_decode.sv
module bsp_decode
  import bsp_pkg::*;
#(
  parameter int unsigned ADDR_LIMIT = 30
) (
  input  logic              valid,
  input  logic [INSN_W-1:0] insn,
  output ctrl_t             ctrl
);

  logic [ADDR_W-1:0] fld;
  logic              is_ext;
  aop_e              aop;
  xop_e              xop;

  always_comb begin
    fld    = insn[INSN_W-1:INSN_W-ADDR_W];
    is_ext = (fld >= ADDR_W'(ADDR_LIMIT));
    aop    = aop_e'(insn[2:0]);
    xop    = xop_e'(insn[3:0]);

    ctrl          = '0;
    ctrl.top_op   = TOP_KEEP;
    ctrl.push_val = PV_ZERO;
    ctrl.addr     = fld;

    if (valid) begin
      if (!is_ext) begin
        case (aop)
          AOP_AND_IN:  ctrl.top_op = TOP_OPND;
          AOP_ANDN_IN: begin
            ctrl.top_op   = TOP_OPND;
            ctrl.opnd_neg = 1'b1;
          end
          AOP_AND_ST: begin
            ctrl.top_op     = TOP_OPND;
            ctrl.opnd_store = 1'b1;
          end
          AOP_ANDN_ST: begin
            ctrl.top_op     = TOP_OPND;
            ctrl.opnd_store = 1'b1;
            ctrl.opnd_neg   = 1'b1;
          end
          AOP_AND_ST_P1: begin
            ctrl.top_op     = TOP_OPND;
            ctrl.opnd_store = 1'b1;
            ctrl.push       = 1'b1;
            ctrl.push_val   = PV_ONE;
          end
          AOP_ANDN_ST_P1: begin
            ctrl.top_op     = TOP_OPND;
            ctrl.opnd_store = 1'b1;
            ctrl.opnd_neg   = 1'b1;
            ctrl.push       = 1'b1;
            ctrl.push_val   = PV_ONE;
          end
          AOP_STORE: begin
            ctrl.top_op   = TOP_ONE;
            ctrl.store_wr = 1'b1;
          end
          AOP_OUT: begin
            ctrl.top_op = TOP_ONE;
            ctrl.out_wr = 1'b1;
          end
          default: ctrl.top_op = TOP_KEEP;
        endcase
      end else begin
        case (xop)
          XOP_RESTART: ctrl.restart   = 1'b1;
          XOP_INVERT:  ctrl.top_op    = TOP_INV;
          XOP_PAGE:    ctrl.page_inc  = 1'b1;
          XOP_HOME:    ctrl.page_home = 1'b1;
          XOP_PUSH0: begin
            ctrl.push     = 1'b1;
            ctrl.push_val = PV_ZERO;
          end
          XOP_PUSH1: begin
            ctrl.push     = 1'b1;
            ctrl.push_val = PV_ONE;
          end
          XOP_PUSHC: begin
            ctrl.push     = 1'b1;
            ctrl.push_val = PV_TOP;
          end
          XOP_POP:     ctrl.pop    = 1'b1;
          XOP_AND:     ctrl.top_op = TOP_AND_BL;
          XOP_OR:      ctrl.top_op = TOP_OR_BL;
          XOP_XOR:     ctrl.top_op = TOP_XOR_BL;
          XOP_PAND: begin
            ctrl.top_op   = TOP_AND_BL;
            ctrl.push     = 1'b1;
            ctrl.push_val = PV_ONE;
          end
          XOP_POR: begin
            ctrl.top_op   = TOP_OR_BL;
            ctrl.push     = 1'b1;
            ctrl.push_val = PV_ONE;
          end
          XOP_PXOR: begin
            ctrl.top_op   = TOP_XOR_BL;
            ctrl.push     = 1'b1;
            ctrl.push_val = PV_ONE;
          end
          default: ctrl.top_op = TOP_KEEP; // compare codes: no operation
        endcase
      end
    end
  end

endmodule

// File: rtl/bsp_stack.sv
module bsp_stack #(
  parameter int unsigned DEPTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  logic top_nxt,
  input  logic push_bit,
  output logic top,
  output logic below
);

  logic [DEPTH-1:0] stk_q, stk_d;

  always_comb begin
    stk_d = stk_q;
    if (push) begin
      stk_d[0] = push_bit;
      stk_d[1] = top_nxt;
      for (int i = 2; i < DEPTH; i++) stk_d[i] = stk_q[i-1];
    end else if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) stk_d[i] = stk_q[i+1];
      stk_d[DEPTH-1] = 1'b0;
    end else begin
      stk_d[0] = top_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stk_q <= DEPTH'(1);
    else     stk_q <= stk_d;
  end

  assign top   = stk_q[0];
  assign below = stk_q[1];

  AST_PUSH_LAYOUT: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(push) |-> top == $past(push_bit) && below == $past(top_nxt)); // R4

  AST_POP_REVEALS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(pop) && !$past(push) |-> top == $past(below)); // R12

endmodule

// File: rtl/bsp_store.sv
module bsp_store
  import bsp_pkg::*;
#(
  parameter int unsigned PAGES = 4,
  parameter int unsigned CELLS = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              wr_bit,
  input  logic              page_inc,
  input  logic              page_home,
  output logic              rd_bit
);

  localparam int unsigned PG_W  = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int unsigned BITS  = PAGES * CELLS;
  localparam int unsigned IDX_W = $clog2(BITS);

  logic [PG_W-1:0]  page_q;
  logic [BITS-1:0]  cells_q;
  logic [IDX_W-1:0] idx;

  assign idx    = IDX_W'(page_q) * IDX_W'(CELLS) + IDX_W'(addr);
  assign rd_bit = cells_q[idx];

  always_ff @(posedge clk) begin
    if (rst)              page_q <= '0;
    else if (page_home)   page_q <= '0;
    else if (page_inc)    page_q <= (page_q == PG_W'(PAGES - 1)) ? '0 : page_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)     cells_q      <= '0;
    else if (wr) cells_q[idx] <= wr_bit;
  end

  AST_HOME_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(page_home) |-> page_q == '0); // R11

  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(page_inc) && !$past(page_home) && $past(page_q) == PG_W'(PAGES - 1)
    |-> page_q == '0); // R11

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && !$past(page_inc) && !$past(page_home) |-> $stable(page_q)); // R11

endmodule

// File: rtl/bsp_core.sv
module bsp_core
  import bsp_pkg::*;
#(
  parameter int unsigned PC_W  = 10,
  parameter int unsigned IO_W  = 30,
  parameter int unsigned PAGES = 4,
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   rom_addr,
  input  logic [INSN_W-1:0] rom_data,
  input  logic [IO_W-1:0]   in_bus,
  output logic [IO_W-1:0]   out_bus
);

  logic [PC_W-1:0] pc_q;
  logic            exec_q;
  ctrl_t           ctrl;
  logic            st_rd, opnd, top, below, top_nxt, push_bit;
  logic [IO_W-1:0] out_q;

  bsp_decode #(.ADDR_LIMIT(IO_W)) u_dec (
    .valid (exec_q),
    .insn  (rom_data),
    .ctrl  (ctrl)
  );

  bsp_store #(.PAGES(PAGES), .CELLS(IO_W)) u_st (
    .clk       (clk),
    .rst       (rst),
    .addr      (ctrl.addr),
    .wr        (ctrl.store_wr),
    .wr_bit    (top),
    .page_inc  (ctrl.page_inc),
    .page_home (ctrl.page_home),
    .rd_bit    (st_rd)
  );

  bsp_stack #(.DEPTH(DEPTH)) u_stk (
    .clk      (clk),
    .rst      (rst),
    .push     (ctrl.push),
    .pop      (ctrl.pop),
    .top_nxt  (top_nxt),
    .push_bit (push_bit),
    .top      (top),
    .below    (below)
  );

  always_comb begin
    opnd = (ctrl.opnd_store ? st_rd : in_bus[ctrl.addr]) ^ ctrl.opnd_neg;
    case (ctrl.top_op)
      TOP_OPND:   top_nxt = top & opnd;
      TOP_ONE:    top_nxt = 1'b1;
      TOP_INV:    top_nxt = ~top;
      TOP_AND_BL: top_nxt = top & below;
      TOP_OR_BL:  top_nxt = top | below;
      TOP_XOR_BL: top_nxt = top ^ below;
      default:    top_nxt = top;
    endcase
    case (ctrl.push_val)
      PV_ONE:  push_bit = 1'b1;
      PV_TOP:  push_bit = top;
      default: push_bit = 1'b0;
    endcase
  end

  // fetch sequencer: one byte per clock, restart squashes the byte in flight
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      exec_q <= 1'b0;
    end else if (ctrl.restart) begin
      pc_q   <= '0;
      exec_q <= 1'b0;
    end else begin
      pc_q   <= pc_q + 1'b1;
      exec_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              out_q              <= '0;
    else if (ctrl.out_wr) out_q[ctrl.addr]   <= top;
  end

  assign rom_addr = pc_q;
  assign out_bus  = out_q;

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && !$past(ctrl.out_wr) |-> $stable(out_bus)); // R5

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && !$past(ctrl.restart) |-> rom_addr == $past(rom_addr) + PC_W'(1)); // R13

  AST_RESTART_SQUASH: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(ctrl.restart) |-> rom_addr == '0 && !exec_q); // R10

  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.push && ctrl.pop)); // R6

endmodule

// File: tb/sim_bsp_core.sv
module sim_bsp_core;
  localparam int PC_W = 10;
  localparam int IO_W = 30;

  localparam logic [7:0] RESTART = 8'hF0, INVERT = 8'hF1, PAGE = 8'hF2, HOME = 8'hF3;
  localparam logic [7:0] PUSH0 = 8'hF4, PUSH1 = 8'hF5, PUSHC = 8'hF6, POP = 8'hF7;
  localparam logic [7:0] ANDB = 8'hF8, ORB = 8'hF9, XORB = 8'hFA, CMP = 8'hFB;
  localparam logic [7:0] PAND = 8'hFC, POR = 8'hFD, PXOR = 8'hFE, PCMP = 8'hFF;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] rom_addr;
  logic [7:0]      rom_data = 8'h00;
  logic [IO_W-1:0] in_bus = '0;
  logic [IO_W-1:0] out_bus;
  logic [7:0]      rom [1024];
  int n_chk = 0, n_fail = 0, pp = 0;

  always #5 clk = ~clk;
  always_ff @(posedge clk) rom_data <= rom[rom_addr];

  bsp_core u0 (
    .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
    .in_bus(in_bus), .out_bus(out_bus)
  );

  function automatic logic [7:0] ins(int a, int o);
    return {a[4:0], o[2:0]};
  endfunction

  task automatic clear_rom();
    for (int i = 0; i < 1024; i++) rom[i] = CMP;
    pp = 0;
  endtask

  task automatic emit(logic [7:0] b);
    rom[pp] = b;
    pp++;
  endtask

  task automatic boot();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    clear_rom();
    emit(ins(0, 7)); emit(ins(5, 2)); emit(ins(1, 7)); emit(ins(5, 6));
    boot(); run(pp + 3);
    @(negedge clk) rst = 1'b1;
    run(2);
    check("R1 out cleared", 32'(out_bus), 32'h0);
    check("R1 rom_addr zero", 32'(rom_addr), 32'h0);
    rst = 1'b0;
    run(pp + 3);
    check("R1 top one, store cleared", 32'(out_bus), 32'h1);
  endtask

  task automatic t_inputs();
    clear_rom();
    in_bus = '0; in_bus[3] = 1'b1;
    emit(ins(3, 0)); emit(ins(0, 7));
    emit(ins(4, 0)); emit(ins(1, 7));
    emit(ins(4, 1)); emit(ins(2, 7));
    emit(ins(3, 1)); emit(ins(3, 7));
    emit(ins(3, 0)); emit(ins(4, 0)); emit(ins(4, 7));
    boot(); run(pp + 3);
    check("R2 input and/and-not", 32'(out_bus), 32'h05);
    in_bus = '0;
  endtask

  task automatic t_store();
    clear_rom();
    emit(ins(7, 6));
    emit(ins(7, 2)); emit(ins(0, 7));
    emit(ins(7, 3)); emit(ins(1, 7));
    emit(ins(8, 2)); emit(ins(2, 7));
    emit(ins(8, 3)); emit(ins(3, 7));
    emit(PUSH0); emit(ins(9, 6)); emit(ins(4, 7));
    emit(ins(9, 2)); emit(ins(5, 7));
    boot(); run(pp + 3);
    check("R3 store and/and-not/store", 32'(out_bus), 32'h19);
  endtask

  task automatic t_and_push();
    clear_rom();
    emit(ins(2, 6));
    emit(ins(2, 5)); emit(ins(0, 7)); emit(POP); emit(ins(1, 7));
    emit(ins(3, 4)); emit(ins(2, 7)); emit(POP); emit(ins(3, 7));
    boot(); run(pp + 3);
    check("R4 and-store then push 1", 32'(out_bus), 32'h05);
  endtask

  task automatic t_ext_basic();
    clear_rom();
    emit(PUSH0); emit(ins(0, 7));
    emit(INVERT); emit(ins(1, 7));
    emit(PUSH0); emit(INVERT); emit(ins(2, 7));
    emit(PUSH0); emit(PUSHC); emit(POP); emit(ins(3, 7));
    emit(PUSH1); emit(PUSH0); emit(POP); emit(ins(4, 7));
    emit(PUSH0); emit(PUSH1); emit(PUSHC); emit(POP); emit(ins(5, 7));
    emit(POP); emit(ins(6, 7));
    boot(); run(pp + 3);
    check("R6 invert/push/pop", 32'(out_bus), 32'h34);
  endtask

  task automatic t_inplace();
    clear_rom();
    emit(PUSH1); emit(PUSH0); emit(ANDB); emit(ins(0, 7)); emit(POP); emit(ins(1, 7));
    emit(PUSH1); emit(PUSH0); emit(ORB); emit(ins(2, 7));
    emit(PUSH1); emit(PUSH1); emit(XORB); emit(ins(3, 7));
    emit(PUSH0); emit(PUSH1); emit(XORB); emit(ins(4, 7));
    emit(PUSH0); emit(PUSH0); emit(ORB); emit(ins(5, 7));
    boot(); run(pp + 3);
    check("R7 in-place and/or/xor", 32'(out_bus), 32'h16);
  endtask

  task automatic t_push_combine();
    clear_rom();
    emit(PUSH0); emit(PUSH1); emit(PAND); emit(ins(0, 7)); emit(POP); emit(ins(1, 7));
    emit(POP); emit(ins(2, 7));
    emit(PUSH1); emit(PUSH1); emit(PXOR); emit(ins(3, 7)); emit(POP); emit(ins(4, 7));
    emit(PUSH0); emit(PUSH1); emit(POR); emit(POP); emit(ins(5, 7));
    boot(); run(pp + 3);
    check("R8 combine then push 1", 32'(out_bus), 32'h29);
  endtask

  task automatic t_nops();
    clear_rom();
    emit(PUSH0); emit(CMP); emit(PCMP); emit(ins(0, 7));
    emit(PUSH1); emit(PCMP); emit(ins(1, 7));
    boot(); run(pp + 3);
    check("R9 compare codes are no-ops", 32'(out_bus), 32'h2);
  endtask

  task automatic t_restart();
    clear_rom();
    in_bus = '0;
    emit(ins(0, 0)); emit(ins(0, 7)); emit(RESTART); emit(ins(2, 7));
    boot(); run(4);
    check("R10 pc back to 0", 32'(rom_addr), 32'h0);
    run(20);
    check("R10 byte after restart skipped", 32'(out_bus[2]), 32'h0);
    check("R10 loop output low", 32'(out_bus[0]), 32'h0);
    in_bus[0] = 1'b1;
    run(10);
    check("R10 loop follows input", 32'(out_bus), 32'h1);
    in_bus = '0;
  endtask

  task automatic t_paging();
    clear_rom();
    emit(ins(5, 6)); emit(PAGE);
    emit(ins(5, 2)); emit(ins(0, 7));
    emit(ins(6, 6)); emit(PAGE); emit(PAGE); emit(PAGE);
    emit(ins(5, 2)); emit(ins(1, 7));
    emit(ins(6, 2)); emit(ins(2, 7));
    emit(PAGE); emit(HOME); emit(ins(5, 2)); emit(ins(3, 7));
    emit(PAGE); emit(ins(6, 2)); emit(ins(4, 7));
    boot(); run(pp + 3);
    check("R11 page select/wrap/home", 32'(out_bus), 32'h1A);
  endtask

  task automatic t_depth();
    clear_rom();
    emit(PUSH1);
    for (int i = 0; i < 7; i++) emit(PUSH0);
    for (int i = 0; i < 7; i++) emit(POP);
    emit(ins(0, 7));
    emit(POP); emit(ins(1, 7));
    emit(POP); emit(ins(2, 7));
    boot(); run(pp + 3);
    check("R12 depth 8, oldest dropped, empty reads 0", 32'(out_bus), 32'h1);
  endtask

  task automatic t_timing();
    clear_rom();
    emit(ins(0, 7));
    boot(); run(1);
    check("R13 addr after edge 1", 32'(rom_addr), 32'h1);
    check("R13 not yet executed", 32'(out_bus), 32'h0);
    run(1);
    check("R13 byte 0 at edge 2", 32'(out_bus), 32'h1);
    check("R13 addr after edge 2", 32'(rom_addr), 32'h2);
    run(1022);
    check("R13 pc wraps at 1024", 32'(rom_addr), 32'h0);
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear_rom();
    t_reset();
    t_inputs();
    t_store();
    t_and_push();
    t_ext_basic();
    t_inplace();
    t_push_combine();
    t_nops();
    t_restart();
    t_paging();
    t_depth();
    t_timing();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule